// File: doc/BRIEF.md
# NAND Column Pointer and Address Latch

This block is the address side of the device end of a byte-wide NAND flash port on which commands, addresses and data share one bus. It watches the already-synchronised, single-cycle write strobes for commands and for address bytes, and it builds the byte column and the row (page) address from them. Three commands move a column pointer between the low half of the page, the high half of the page and the 16-byte spare field. That pointer sets the column base that the first address byte is added to.

During a sequential read each read strobe steps the column forward. Past the final byte of a page the row moves to the next page, but only inside the current 32-page block. At the last page of a block the counters freeze and wait for a new command. An erase-setup command switches the latch to a row-only, three-byte address form. The block sends the current column, the row and the active pointer region to the page register and array decoders.

Top module: `nand_colptr_latch`

## Requirements
- R1: After a synchronous reset the pointer region is the low half (code 0), the column is 0, the row is 0 and the stop flag is low.
- R2: Command 00h selects region code 0 and command 50h selects region code 2. Either choice persists through any number of end-of-operation pulses until another pointer command arrives.
- R3: Command 01h selects region code 1 for one operation only. The next end-of-operation pulse returns the pointer to region code 0.
- R4: After any command other than 60h, the address bytes load in a fixed order: column byte, row bits 7:0, row bits 15:8, then row bit 16 from bit 0 of the fourth byte. The upper bits of the fourth byte and any fifth or later address byte have no effect.
- R5: The column loaded by the first address byte is the byte value in region 0, 256 plus the byte in region 1, and 512 plus the low four bits of the byte in region 2 (bits 7:4 ignored).
- R6: Each read strobe below column 527 raises the column by exactly one and leaves the row unchanged.
- R7: A read strobe at column 527, when the page field (row bits 4:0) is not 31, raises the row by one. The column then restarts at 0 in regions 0 and 1 and at 512 in region 2.
- R8: A read strobe at column 527 on page 31 of a block sets the stop flag and leaves row and column unchanged. While the flag is set, read strobes have no effect. Any command clears the flag.
- R9: After command 60h, three address bytes load row bits 7:0, 15:8 and bit 16. Row bits 4:0 are forced to zero, and the column is not changed.
- R10: Pointer commands do not change the column or the row. Only address bytes and read strobes move them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_we | input | 1 | One-cycle strobe: io_in holds a command byte |
| addr_we | input | 1 | One-cycle strobe: io_in holds an address byte |
| io_in | input | 8 | Shared command/address bus byte |
| rd_stb | input | 1 | One-cycle read strobe, one byte consumed |
| op_done | input | 1 | One-cycle pulse marking the end of an operation |
| col_addr | output | 10 | Current byte column, 0 to 527 |
| row_addr | output | 17 | Current row (page) address |
| region | output | 2 | Active pointer region: 0 low half, 1 high half, 2 spare |
| seq_stop | output | 1 | High when a sequential read has reached the end of a block |

## Verification
The first address byte is swept over all 256 values in each of the three regions. This separates the three column base computations and shows that the upper nibble is dropped only in the spare region. A full walk of read strobes across one page shows the single-step increment and the wrap at 527. The same wrap from the spare region shows the restart at 512 instead of 0. Starting a read near the end of page 31 separates page advance from block stop. Four-byte, five-byte and erase-form address sequences show the byte lane order, the fourth-byte masking and the zeroed page field. Pointer commands followed by end-of-operation pulses separate the persistent regions from the one-shot region.

// File: rtl/nand_ptr_pkg.sv
package nand_ptr_pkg;
   typedef enum logic [1:0] {
      RG_LO    = 2'd0,
      RG_HI    = 2'd1,
      RG_SPARE = 2'd2
   } region_t;

   localparam logic [7:0] CMD_PTR_LO    = 8'h00;
   localparam logic [7:0] CMD_PTR_HI    = 8'h01;
   localparam logic [7:0] CMD_PTR_SPARE = 8'h50;
   localparam logic [7:0] CMD_ERASE_SET = 8'h60;
endpackage

// File: rtl/nand_ptr_sel.sv
module nand_ptr_sel
   import nand_ptr_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       cmd_we,
   input  logic [7:0] io_in,
   input  logic       op_done,
   output region_t    ptr
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ptr <= RG_LO;
      end else if (cmd_we && io_in == CMD_PTR_LO) begin
         ptr <= RG_LO;
      end else if (cmd_we && io_in == CMD_PTR_HI) begin
         ptr <= RG_HI;
      end else if (cmd_we && io_in == CMD_PTR_SPARE) begin
         ptr <= RG_SPARE;
      end else if (op_done && ptr == RG_HI) begin
         ptr <= RG_LO;
      end
   end

   AST_ONESHOT_FALLBACK: assert property (@(posedge clk) disable iff (rst)
      (op_done && !cmd_we && ptr == RG_HI) |=> ptr == RG_LO); // R3

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (op_done && !cmd_we && ptr != RG_HI) |=> $stable(ptr)); // R2
endmodule

// File: rtl/nand_addr_cap.sv
module nand_addr_cap
   import nand_ptr_pkg::*;
#(
   parameter int HALF_BYTES  = 256,
   parameter int SPARE_BYTES = 16,
   parameter int ROW_BITS    = 17,
   localparam int COL_W  = $clog2(2*HALF_BYTES + SPARE_BYTES),
   localparam int LANES  = (ROW_BITS + 7) / 8
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_we,
   input  logic             addr_we,
   input  logic [7:0]       io_in,
   input  region_t          ptr,
   output logic             col_ld,
   output logic [COL_W-1:0] col_val,
   output logic [LANES-1:0] row_ld,
   output logic             page_clr
);
   localparam int HALF_W = $clog2(HALF_BYTES);
   localparam int SP_W   = $clog2(SPARE_BYTES);
   localparam int CNT_W  = $clog2(LANES + 2);

   logic [CNT_W-1:0] acnt;
   logic             erase_form;

   if (HALF_W > 8 || SP_W > HALF_W) begin : g_bad_col
      $error("column regions do not fit one address byte");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acnt       <= '0;
         erase_form <= 1'b0;
      end else if (cmd_we) begin
         acnt       <= '0;
         erase_form <= (io_in == CMD_ERASE_SET);
      end else if (addr_we && acnt <= CNT_W'(LANES)) begin
         acnt <= acnt + 1'b1;
      end
   end

   assign col_ld   = addr_we && !cmd_we && !erase_form && acnt == '0;
   assign page_clr = erase_form;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign row_ld[g] = addr_we && !cmd_we &&
                         (erase_form ? (acnt == CNT_W'(g)) : (acnt == CNT_W'(g + 1)));
   end

   always_comb begin
      unique case (ptr)
         RG_HI:    col_val = COL_W'(HALF_BYTES) + COL_W'(io_in[HALF_W-1:0]);
         RG_SPARE: col_val = COL_W'(2*HALF_BYTES) + COL_W'(io_in[SP_W-1:0]);
         default:  col_val = COL_W'(io_in[HALF_W-1:0]);
      endcase
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
      $countones({col_ld, row_ld}) <= 1); // R4
endmodule

// File: rtl/nand_seq_ctr.sv
module nand_seq_ctr
   import nand_ptr_pkg::*;
#(
   parameter int HALF_BYTES  = 256,
   parameter int SPARE_BYTES = 16,
   parameter int ROW_BITS    = 17,
   parameter int BLK_PAGES   = 32,
   localparam int COL_W = $clog2(2*HALF_BYTES + SPARE_BYTES),
   localparam int LANES = (ROW_BITS + 7) / 8
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                cmd_we,
   input  logic                rd_stb,
   input  logic [7:0]          io_in,
   input  region_t             ptr,
   input  logic                col_ld,
   input  logic [COL_W-1:0]    col_val,
   input  logic [LANES-1:0]    row_ld,
   input  logic                page_clr,
   output logic [COL_W-1:0]    col,
   output logic [ROW_BITS-1:0] row,
   output logic                stop
);
   localparam int PG_BITS = $clog2(BLK_PAGES);
   localparam logic [COL_W-1:0] LAST_COL   = COL_W'(2*HALF_BYTES + SPARE_BYTES - 1);
   localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(2*HALF_BYTES);

   if ((1 << PG_BITS) != BLK_PAGES || PG_BITS > 8) begin : g_bad_blk
      $error("block page count must be a power of two within the first row byte");
   end

   logic [ROW_BITS-1:0] row_load;
   logic                any_row_ld;
   logic                rd_go;
   logic                at_end;
   logic                blk_last;

   always_comb begin
      row_load = row;
      for (int b = 0; b < ROW_BITS; b++) begin
         if (row_ld[b/8]) row_load[b] = io_in[b%8];
      end
      if (row_ld[0] && page_clr) row_load[PG_BITS-1:0] = '0;
   end

   assign any_row_ld = |row_ld;
   assign rd_go      = rd_stb && !stop && !cmd_we && !col_ld && !any_row_ld;
   assign at_end     = (col == LAST_COL);
   assign blk_last   = &row[PG_BITS-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         col  <= '0;
         row  <= '0;
         stop <= 1'b0;
      end else begin
         if (cmd_we) stop <= 1'b0;
         if (col_ld) col <= col_val;
         if (any_row_ld) row <= row_load;
         if (rd_go) begin
            if (!at_end) begin
               col <= col + 1'b1;
            end else if (blk_last) begin
               stop <= 1'b1;
            end else begin
               row <= row + 1'b1;
               col <= (ptr == RG_SPARE) ? SPARE_BASE : '0;
            end
         end
      end
   end

   AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
      col <= LAST_COL); // R6

   AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && !stop && !cmd_we && !col_ld && !any_row_ld && col != LAST_COL)
      |=> col == $past(col) + 1'b1); // R6

   AST_NO_BLOCK_CROSS: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && !cmd_we && !any_row_ld)
      |=> row[ROW_BITS-1:PG_BITS] == $past(row[ROW_BITS-1:PG_BITS])); // R8

   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (stop && !cmd_we && !addr_active())
      |=> $stable(col) && $stable(row) && stop); // R8

   function automatic logic addr_active();
      return col_ld || any_row_ld;
   endfunction
endmodule

// File: rtl/nand_colptr_latch.sv
module nand_colptr_latch
   import nand_ptr_pkg::*;
#(
   parameter int HALF_BYTES  = 256,
   parameter int SPARE_BYTES = 16,
   parameter int ROW_BITS    = 17,
   parameter int BLK_PAGES   = 32,
   localparam int COL_W = $clog2(2*HALF_BYTES + SPARE_BYTES),
   localparam int LANES = (ROW_BITS + 7) / 8
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                cmd_we,
   input  logic                addr_we,
   input  logic [7:0]          io_in,
   input  logic                rd_stb,
   input  logic                op_done,
   output logic [COL_W-1:0]    col_addr,
   output logic [ROW_BITS-1:0] row_addr,
   output logic [1:0]          region,
   output logic                seq_stop
);
   region_t          ptr;
   logic             col_ld;
   logic [COL_W-1:0] col_val;
   logic [LANES-1:0] row_ld;
   logic             page_clr;

   nand_ptr_sel u_ptr (
      .clk(clk), .rst(rst), .cmd_we(cmd_we), .io_in(io_in),
      .op_done(op_done), .ptr(ptr)
   );

   nand_addr_cap #(
      .HALF_BYTES(HALF_BYTES), .SPARE_BYTES(SPARE_BYTES), .ROW_BITS(ROW_BITS)
   ) u_cap (
      .clk(clk), .rst(rst), .cmd_we(cmd_we), .addr_we(addr_we), .io_in(io_in),
      .ptr(ptr), .col_ld(col_ld), .col_val(col_val), .row_ld(row_ld),
      .page_clr(page_clr)
   );

   nand_seq_ctr #(
      .HALF_BYTES(HALF_BYTES), .SPARE_BYTES(SPARE_BYTES), .ROW_BITS(ROW_BITS),
      .BLK_PAGES(BLK_PAGES)
   ) u_seq (
      .clk(clk), .rst(rst), .cmd_we(cmd_we), .rd_stb(rd_stb), .io_in(io_in),
      .ptr(ptr), .col_ld(col_ld), .col_val(col_val), .row_ld(row_ld),
      .page_clr(page_clr), .col(col_addr), .row(row_addr), .stop(seq_stop)
   );

   assign region = ptr;

   AST_PTR_CMD_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
      (cmd_we && (io_in == CMD_PTR_LO || io_in == CMD_PTR_HI || io_in == CMD_PTR_SPARE))
      |=> $stable(col_addr) && $stable(row_addr)); // R10

   AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (rst)
      region != 2'd3); // R2
endmodule

// File: tb/nand_colptr_latch_test.sv
module nand_colptr_latch_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_we = 1'b0, addr_we = 1'b0, rd_stb = 1'b0, op_done = 1'b0;
   logic [7:0]  io_in = 8'h00;
   logic [9:0]  col_addr;
   logic [16:0] row_addr;
   logic [1:0]  region;
   logic        seq_stop;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   nand_colptr_latch uut (
      .clk(clk), .rst(rst), .cmd_we(cmd_we), .addr_we(addr_we), .io_in(io_in),
      .rd_stb(rd_stb), .op_done(op_done), .col_addr(col_addr),
      .row_addr(row_addr), .region(region), .seq_stop(seq_stop)
   );

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cmd(input logic [7:0] b);
      @(negedge clk); cmd_we = 1'b1; io_in = b;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic adr(input logic [7:0] b);
      @(negedge clk); addr_we = 1'b1; io_in = b;
      @(negedge clk); addr_we = 1'b0;
   endtask

   task automatic rd();
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   task automatic fin();
      @(negedge clk); op_done = 1'b1;
      @(negedge clk); op_done = 1'b0;
   endtask

   task automatic full_addr(input logic [7:0] c, input logic [16:0] r);
      adr(c); adr(r[7:0]); adr(r[15:8]); adr({7'd0, r[16]});
   endtask

   initial begin
      #2_000_000;
      if (!done_flag) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int exp_col;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check("R1", "region", region, 0);
      check("R1", "col", col_addr, 0);
      check("R1", "row", row_addr, 0);
      check("R1", "stop", seq_stop, 0);

      // R5 column base sweep over all bytes in every region
      for (int m = 0; m < 3; m++) begin
         for (int b = 0; b < 256; b++) begin
            cmd(m == 0 ? 8'h00 : (m == 1 ? 8'h01 : 8'h50));
            adr(8'(b));
            exp_col = (m == 0) ? b : (m == 1 ? 256 + b : 512 + (b % 16));
            check("R5", "col base", col_addr, exp_col);
            check("R2", "region", region, m);
         end
      end

      // R10 pointer command keeps column and row
      cmd(8'h50); full_addr(8'h07, 17'h0_4321);
      cmd(8'h00);
      check("R10", "col after ptr cmd", col_addr, 519);
      check("R10", "row after ptr cmd", row_addr, 17'h0_4321);

      // R2 sticky regions
      cmd(8'h50); fin(); fin();
      check("R2", "spare sticky", region, 2);
      cmd(8'h00); fin();
      check("R2", "low sticky", region, 0);
      // R3 one-shot
      cmd(8'h01);
      check("R3", "hi selected", region, 1);
      fin();
      check("R3", "hi falls back", region, 0);

      // R4 order, fourth byte masking, extra byte ignored
      cmd(8'h00);
      adr(8'h10); adr(8'h34); adr(8'h12); adr(8'hFF); adr(8'h77);
      check("R4", "col", col_addr, 16);
      check("R4", "row", row_addr, 17'h1_1234);

      // R9 erase form
      cmd(8'h60);
      adr(8'hFF); adr(8'hAB); adr(8'h03); adr(8'h55);
      check("R9", "row", row_addr, 17'h1_ABE0);
      check("R9", "col unchanged", col_addr, 16);

      // R6 / R7 full page walk in low region
      cmd(8'h00); full_addr(8'h00, 17'h0_0021);
      for (int i = 0; i < 527; i++) begin
         rd();
         check("R6", "col step", col_addr, i + 1);
      end
      check("R6", "row held", row_addr, 17'h0_0021);
      rd();
      check("R7", "col wraps to 0", col_addr, 0);
      check("R7", "next page", row_addr, 17'h0_0022);

      // R7 spare wrap
      cmd(8'h50); full_addr(8'h0D, 17'h0_0025);
      check("R5", "spare start", col_addr, 525);
      rd(); rd();
      check("R6", "spare at end", col_addr, 527);
      rd();
      check("R7", "spare restart", col_addr, 512);
      check("R7", "spare next page", row_addr, 17'h0_0026);

      // R7 high one-shot wrap restarts at 0
      cmd(8'h01); full_addr(8'hFF, 17'h0_0040);
      for (int i = 0; i < 16; i++) rd();
      check("R6", "hi at end", col_addr, 527);
      rd();
      check("R7", "hi restart", col_addr, 0);
      check("R7", "hi next page", row_addr, 17'h0_0041);

      // R8 block end
      cmd(8'h50); full_addr(8'h08, 17'h0_005F);
      for (int i = 0; i < 7; i++) rd();
      check("R8", "col at 527", col_addr, 527);
      check("R8", "no stop yet", seq_stop, 0);
      rd();
      check("R8", "stop set", seq_stop, 1);
      check("R8", "row held", row_addr, 17'h0_005F);
      check("R8", "col held", col_addr, 527);
      rd(); rd();
      check("R8", "stopped col", col_addr, 527);
      check("R8", "stopped row", row_addr, 17'h0_005F);
      cmd(8'h00);
      check("R8", "cmd clears stop", seq_stop, 0);

      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule